// File: doc/BRIEF.md
# DRAM Access Cycle Sequencer

This block steps one DRAM bus access through its timing states: one or two precharge states, a row-address state, a first column state, optional wait states, and a final column state. A request carries a read/write flag, a row address and a column address. The block drives the multiplexed address, the active-low row and column strobes, the active-low write enable, a read-data capture strobe and a one-cycle completion pulse.

Waits come from two sources. A per-area enable allows a 2-bit programmed count of 0 to 3 wait states. A separate enable lets an external active-low wait line stretch the access after the programmed waits have run out. That line is sampled on the falling clock edge. A refresh request runs only the precharge states, with the same one-or-two length, and then completes. The configuration is captured when an access starts, so changes during a cycle do not affect it.

Top module: `dram_access_seq`

## Requirements
- R1: An access or refresh starts with one precharge state when `cfg_two_pre` is 0 and with two when it is 1; `ras_n` and `cas_n` are high during precharge.
- R2: After precharge the order is one row state, one first-column state, zero or more wait states and one final-column state. With no waits an access occupies P+3 cycles, where P is the precharge count.
- R3: When `cfg_prog_en` is 1, exactly `cfg_prog_cnt` (0 to 3) wait states follow the first-column state. When it is 0, the count is ignored and no programmed waits are inserted.
- R4: When `cfg_pin_en` is 1, the wait line extends the access even if `cfg_prog_en` is 0. When `cfg_pin_en` is 0, a low `wait_n` has no effect on the access length.
- R5: Pin waits start only after the programmed waits. If `wait_n` is low at the falling edge of the last first-column or wait state, one more wait state follows. This repeats until `wait_n` is seen high, and then the final-column state follows.
- R6: A refresh request runs only the precharge states, with `ras_n`, `cas_n` and `we_n` high throughout, and `done` pulses in the last precharge state. When a refresh and an access are requested in the same idle cycle, the refresh is taken.
- R7: `ras_n` is low from the row state through the final-column state. `cas_n` is low from the first-column state through the final-column state, so it is low for W+2 cycles, where W is the total number of wait states.
- R8: `mem_addr` carries the latched row address during precharge and the row state, and the latched column address from the first-column state onward.
- R9: On a write (`acc_wr`=1), `we_n` is low for the whole column phase (W+2 cycles). On a read it stays high.
- R10: `done` is high for exactly one cycle, in the final-column state. `rd_stb` is high in that same cycle for reads only. A request present in the following idle cycle is accepted.
- R11: The configuration inputs and `acc_wr` are latched at acceptance. Changing them during an access does not change its timing or its write enable.
- R12: While reset is held and after it is released, the outputs are idle: `ras_n`, `cas_n` and `we_n` are high, and `done` and `rd_stb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state advances on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Access request, sampled in idle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| row_addr | input | ADDR_W | Row address of the request |
| col_addr | input | ADDR_W | Column address of the request |
| ref_req | input | 1 | Refresh request, takes priority in idle |
| cfg_two_pre | input | 1 | 1 = two precharge states |
| cfg_prog_en | input | 1 | Programmed-wait enable for the area |
| cfg_prog_cnt | input | WCNT_W | Programmed wait count |
| cfg_pin_en | input | 1 | Enables the external wait line |
| wait_n | input | 1 | Active-low wait line, sampled on the falling edge |
| mem_addr | output | ADDR_W | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| rd_stb | output | 1 | Read-data capture strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check the legal state order into the row and second-precharge states and the holding of the latched configuration during an access. They also check that the programmed and pin-driven wait decisions lead to the correct next state, that a refresh never leaves precharge, that the column strobe is never active without the row strobe, and that `done` never lasts more than one cycle. The bench scenarios cover the overall results: total access length for each mix of precharge count, programmed waits and wait-line release time. They also cover strobe and write-enable cycle counts, the address seen in the row and column phases, refresh priority, and the fact that configuration changes made during a cycle are ignored.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_PRE1 = 3'd1,
        S_PRE2 = 3'd2,
        S_ROW  = 3'd3,
        S_COL1 = 3'd4,
        S_WAIT = 3'd5,
        S_COL2 = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic two_pre;
        logic pin_en;
        logic is_wr;
        logic is_ref;
    } cyc_cfg_t;

    function automatic logic in_precharge(seq_state_e s);
        return (s == S_PRE1) || (s == S_PRE2);
    endfunction

    function automatic logic in_column(seq_state_e s);
        return (s == S_COL1) || (s == S_WAIT) || (s == S_COL2);
    endfunction

    function automatic logic row_open(seq_state_e s);
        return (s == S_ROW) || in_column(s);
    endfunction

endpackage

// File: rtl/dram_wait_sampler.sv
module dram_wait_sampler (
    input  logic clk,
    input  logic rst,
    input  logic wait_n,
    output logic wait_s
);
    // Capture the wait line on the falling edge; the FSM uses it on the next rising edge.
    always_ff @(negedge clk) begin
        if (rst) wait_s <= 1'b1;
        else     wait_s <= wait_n;
    end
endmodule

// File: rtl/dram_seq_addr.sv
module dram_seq_addr #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              col_phase,
    input  logic [ADDR_W-1:0] row_in,
    input  logic [ADDR_W-1:0] col_in,
    output logic [ADDR_W-1:0] addr_out
);
    logic [ADDR_W-1:0] row_q;
    logic [ADDR_W-1:0] col_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            col_q <= '0;
        end else if (load) begin
            row_q <= row_in;
            col_q <= col_in;
        end
    end

    assign addr_out = col_phase ? col_q : row_q;
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
    import dram_seq_pkg::*;
#(
    parameter int WCNT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_req,
    input  logic              ref_req,
    input  logic              acc_wr,
    input  logic              two_pre,
    input  logic              prog_en,
    input  logic [WCNT_W-1:0] prog_cnt,
    input  logic              pin_en,
    input  logic              wait_s,
    output seq_state_e        state,
    output cyc_cfg_t          cfg_q,
    output logic              start,
    output logic              ref_last
);
    logic [WCNT_W-1:0] wcnt;
    logic              wait_phase;

    assign start      = (state == S_IDLE) && (acc_req || ref_req);
    assign wait_phase = (state == S_COL1) || (state == S_WAIT);
    assign ref_last   = cfg_q.is_ref &&
                        (((state == S_PRE1) && !cfg_q.two_pre) || (state == S_PRE2));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cfg_q <= '0;
            wcnt  <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (ref_req) begin
                        cfg_q <= '{two_pre: two_pre, pin_en: 1'b0, is_wr: 1'b0, is_ref: 1'b1};
                        wcnt  <= '0;
                        state <= S_PRE1;
                    end else if (acc_req) begin
                        cfg_q <= '{two_pre: two_pre, pin_en: pin_en, is_wr: acc_wr, is_ref: 1'b0};
                        wcnt  <= prog_en ? prog_cnt : '0;
                        state <= S_PRE1;
                    end
                end
                S_PRE1: begin
                    if (cfg_q.two_pre)     state <= S_PRE2;
                    else if (cfg_q.is_ref) state <= S_IDLE;
                    else                   state <= S_ROW;
                end
                S_PRE2: state <= cfg_q.is_ref ? S_IDLE : S_ROW;
                S_ROW:  state <= S_COL1;
                S_COL1, S_WAIT: begin
                    if (wcnt != '0) begin
                        wcnt  <= wcnt - 1'b1;
                        state <= S_WAIT;
                    end else if (cfg_q.pin_en && !wait_s) begin
                        state <= S_WAIT;
                    end else begin
                        state <= S_COL2;
                    end
                end
                S_COL2:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_ROW_AFTER_PRE: assert property (@(posedge clk) disable iff (rst)
        (state == S_ROW) |-> ($past(state) == S_PRE1 || $past(state) == S_PRE2)); // R2
    AST_SECOND_PRE: assert property (@(posedge clk) disable iff (rst)
        (state == S_PRE2) |-> ($past(state) == S_PRE1 && cfg_q.two_pre)); // R1
    AST_PROG_WAIT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (state == S_COL1 && wcnt != '0) |=> (state == S_WAIT)); // R3
    AST_PIN_EXTEND: assert property (@(posedge clk) disable iff (rst)
        (wait_phase && wcnt == '0 && cfg_q.pin_en && !wait_s) |=> (state == S_WAIT)); // R5
    AST_PIN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wait_phase && wcnt == '0 && !cfg_q.pin_en) |=> (state == S_COL2)); // R4
    AST_REF_STAYS_PRE: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.is_ref && state != S_IDLE) |-> in_precharge(state)); // R6
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(cfg_q)); // R11
endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
    import dram_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WCNT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_req,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] row_addr,
    input  logic [ADDR_W-1:0] col_addr,
    input  logic              ref_req,
    input  logic              cfg_two_pre,
    input  logic              cfg_prog_en,
    input  logic [WCNT_W-1:0] cfg_prog_cnt,
    input  logic              cfg_pin_en,
    input  logic              wait_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              rd_stb,
    output logic              done
);
    seq_state_e state;
    cyc_cfg_t   cfg_q;
    logic       start;
    logic       ref_last;
    logic       wait_s;
    logic       col_phase;

    dram_wait_sampler u_wait (
        .clk    (clk),
        .rst    (rst),
        .wait_n (wait_n),
        .wait_s (wait_s)
    );

    dram_seq_fsm #(.WCNT_W(WCNT_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .acc_req  (acc_req),
        .ref_req  (ref_req),
        .acc_wr   (acc_wr),
        .two_pre  (cfg_two_pre),
        .prog_en  (cfg_prog_en),
        .prog_cnt (cfg_prog_cnt),
        .pin_en   (cfg_pin_en),
        .wait_s   (wait_s),
        .state    (state),
        .cfg_q    (cfg_q),
        .start    (start),
        .ref_last (ref_last)
    );

    assign col_phase = in_column(state);

    dram_seq_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .col_phase (col_phase),
        .row_in    (row_addr),
        .col_in    (col_addr),
        .addr_out  (mem_addr)
    );

    assign ras_n  = !row_open(state);
    assign cas_n  = !col_phase;
    assign we_n   = !(col_phase && cfg_q.is_wr);
    assign rd_stb = (state == S_COL2) && !cfg_q.is_wr;
    assign done   = (state == S_COL2) || ref_last;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_CAS_NEEDS_RAS: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !ras_n); // R7
    AST_WE_IN_COLUMN: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !cas_n); // R9
endmodule

// File: tb/dram_access_seq_tb.sv
module dram_access_seq_tb_top;
    localparam int AW = 12;
    localparam int WW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_req = 1'b0, acc_wr = 1'b0, ref_req = 1'b0;
    logic [AW-1:0] row_addr = '0, col_addr = '0;
    logic          cfg_two_pre = 1'b0, cfg_prog_en = 1'b0, cfg_pin_en = 1'b0;
    logic [WW-1:0] cfg_prog_cnt = '0;
    logic          wait_n = 1'b1;
    logic [AW-1:0] mem_addr;
    logic          ras_n, cas_n, we_n, rd_stb, done;

    always #10 clk = ~clk;

    dram_access_seq #(.ADDR_W(AW), .WCNT_W(WW)) dut_i (
        .clk(clk), .rst(rst), .acc_req(acc_req), .acc_wr(acc_wr),
        .row_addr(row_addr), .col_addr(col_addr), .ref_req(ref_req),
        .cfg_two_pre(cfg_two_pre), .cfg_prog_en(cfg_prog_en),
        .cfg_prog_cnt(cfg_prog_cnt), .cfg_pin_en(cfg_pin_en), .wait_n(wait_n),
        .mem_addr(mem_addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .rd_stb(rd_stb), .done(done)
    );

    typedef struct {
        int          total;
        int          ras_lo;
        int          cas_lo;
        int          we_lo;
        logic [AW-1:0] row;
        logic [AW-1:0] col;
        bit          rd;
        bit          is_ref;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   armed  = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Monitor: counts strobe cycles of the running access and compares at done.
    initial begin
        int n = 0, r = 0, c = 0, w = 0;
        forever begin
            @(posedge clk);
            #5;
            if (armed) begin
                if (n == 0 && exp_q.size() > 0 && !exp_q[0].is_ref)
                    chk(mem_addr == exp_q[0].row, "R8 row address in precharge",
                        int'(mem_addr), int'(exp_q[0].row));
                n++;
                if (!ras_n) r++;
                if (!cas_n) c++;
                if (!we_n)  w++;
                if (done) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(n == e.total, {e.tag, " access length"}, n, e.total);
                    chk(r == e.ras_lo, "R7 ras_n low cycles", r, e.ras_lo);
                    chk(c == e.cas_lo, "R7 cas_n low cycles", c, e.cas_lo);
                    chk(w == e.we_lo, "R9 we_n low cycles", w, e.we_lo);
                    chk(rd_stb == e.rd, "R10 rd_stb at done", int'(rd_stb), int'(e.rd));
                    if (!e.is_ref)
                        chk(mem_addr == e.col, "R8 column address at done",
                            int'(mem_addr), int'(e.col));
                    n = 0; r = 0; c = 0; w = 0;
                    armed = 0;
                end
            end
        end
    end

    // Driver: computes the expected item, pushes it, then runs the request.
    task automatic run(input bit is_ref, input bit both, input bit wr,
                       input logic [AW-1:0] row, input logic [AW-1:0] col,
                       input bit two, input bit pen, input logic [WW-1:0] pcnt,
                       input bit pinen, input int rel, input bit scramble,
                       input string tag);
        exp_t e;
        int p, wt, extra;
        p     = two ? 2 : 1;
        wt    = pen ? int'(pcnt) : 0;
        extra = (pinen && rel > 0 && rel > p + 2 + wt) ? rel - (p + 2 + wt) : 0;
        e.is_ref = is_ref;
        e.total  = is_ref ? p : p + 3 + wt + extra;
        e.ras_lo = is_ref ? 0 : 3 + wt + extra;
        e.cas_lo = is_ref ? 0 : 2 + wt + extra;
        e.we_lo  = (is_ref || !wr) ? 0 : 2 + wt + extra;
        e.rd     = !is_ref && !wr;
        e.row    = row;
        e.col    = col;
        e.tag    = tag;
        exp_q.push_back(e);

        acc_wr = wr; row_addr = row; col_addr = col;
        cfg_two_pre = two; cfg_prog_en = pen; cfg_prog_cnt = pcnt; cfg_pin_en = pinen;
        if (rel > 0) wait_n = 1'b0;
        ref_req = is_ref;
        acc_req = !is_ref || both;
        @(posedge clk);
        #1;
        acc_req = 1'b0; ref_req = 1'b0;
        armed = 1;
        if (scramble) begin
            cfg_two_pre = ~two; cfg_prog_en = ~pen; cfg_prog_cnt = ~pcnt;
            cfg_pin_en = ~pinen; acc_wr = ~wr;
        end
        if (rel > 0) begin
            repeat (rel - 1) @(posedge clk);
            #1;
            wait_n = 1'b1;
        end
        wait (armed == 0);
        @(posedge clk);
        #1;
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 20000) begin
                errors++;
                $display("FAIL watchdog expired actual=%0d expected<=%0d", wd, 20000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        chk(ras_n && cas_n && we_n && !done && !rd_stb, "R12 outputs idle in reset",
            int'({ras_n, cas_n, we_n, done, rd_stb}), 5'b11100);
        @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk);
        #5;
        chk(ras_n && cas_n && we_n && !done && !rd_stb, "R12 outputs idle after reset",
            int'({ras_n, cas_n, we_n, done, rd_stb}), 5'b11100);
        #1;

        //  ref both wr  row     col     two pen cnt pin rel scr tag
        run(0, 0, 0, 12'h123, 12'h045, 0, 0, 2'd0, 0, 0, 0, "R2 read one precharge");
        run(0, 0, 1, 12'h3A5, 12'h0F1, 1, 0, 2'd0, 0, 0, 0, "R1 write two precharge");
        run(0, 0, 0, 12'h001, 12'hFFF, 0, 1, 2'd3, 0, 0, 0, "R3 three programmed waits");
        run(0, 0, 1, 12'h7E0, 12'h00F, 0, 0, 2'd3, 0, 0, 0, "R3 count ignored when disabled");
        run(0, 0, 0, 12'h555, 12'hAAA, 0, 1, 2'd2, 1, 8, 0, "R5 pin waits after programmed");
        run(0, 0, 1, 12'h0C3, 12'h3C0, 1, 0, 2'd0, 1, 7, 0, "R4 pin honoured without program wait");
        run(0, 0, 0, 12'h222, 12'h111, 0, 0, 2'd0, 0, 5, 0, "R4 wait line ignored when disabled");
        run(0, 0, 0, 12'h9AB, 12'h4CD, 0, 1, 2'd1, 1, 2, 0, "R5 early release adds nothing");
        run(1, 0, 0, 12'h000, 12'h000, 1, 0, 2'd0, 0, 0, 0, "R6 refresh two precharge");
        run(1, 0, 0, 12'h000, 12'h000, 0, 1, 2'd3, 1, 0, 0, "R6 refresh one precharge");
        run(1, 1, 1, 12'h0AA, 12'h055, 0, 0, 2'd0, 0, 0, 0, "R6 refresh beats access");
        run(0, 0, 0, 12'h456, 12'h789, 0, 0, 2'd0, 0, 0, 0, "R10 back-to-back accept");
        run(0, 0, 1, 12'hF0F, 12'h0F0, 1, 1, 2'd2, 0, 0, 1, "R11 mid-cycle config change");
        run(0, 0, 0, 12'h321, 12'h654, 0, 1, 2'd1, 0, 0, 1, "R11 read held despite change");

        repeat (3) @(posedge clk);
        #5;
        chk(exp_q.size() == 0, "R10 every request completed", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule